// File: doc/BRIEF.md
# Register Bank Exchange Unit

This unit holds three 16-bit general register pairs (BC, DE, HL), a shadow copy of each, two index registers and a stack pointer. It runs two exchange operations. A bank swap trades every primary pair for its shadow counterpart in one step. A stack exchange trades the 16-bit word at the top of a memory stack with HL or with one of the index registers. It does this over a byte-wide memory port and leaves the stack pointer where it was.

The surrounding control logic loads and inspects the registers through a simple write port and a combinational read port. It starts an operation with a one-cycle request. While an operation runs, the unit holds `busy` high. It pulses `done` for one cycle after the operation ends. Each machine cycle of a stack exchange drives one address with a read or write strobe for the whole cycle. Read data is captured in the last clock state of that cycle.

Top module: `regx_unit`

## Requirements
- R1: After reset, every register reads zero, and `busy`, `done`, `mem_rd` and `mem_wr` are low.
- R2: When `busy` is low and `wr_en` is high, the register named by `wr_sel` takes `wr_data` at the clock edge. `rd_data` shows the register named by `rd_sel` combinationally. Select codes: 0 BC, 1 DE, 2 HL, 3 BC', 4 DE', 5 HL', 6 IX, 7 IY, 8 SP.
- R3: A bank swap holds `busy` for 4 clock states. At its end, BC/DE/HL and BC'/DE'/HL' have traded contents. IX, IY and SP are unchanged, and no memory strobe is raised.
- R4: Two bank swaps in a row restore the original contents of all six pairs.
- R5: A stack exchange with HL lasts 19 states, counted from state 0 after the request edge. States 0-3 are idle. States 4-6 read SP. States 7-10 read SP+1. States 11-13 write H to SP+1. States 14-18 write L to SP. HL ends as {byte at SP+1, byte at SP}.
- R6: A stack exchange with an index register lasts 23 states. It follows the same pattern as R5, shifted 4 states later, with the register's high byte written to SP+1 and its low byte to SP.
- R7: With `stk_use_index` high, `stk_index_sel` picks IX (0) or IY (1). Both are captured at the request edge. Only the chosen register changes.
- R8: SP holds the same value before and after any exchange. SP+1 wraps modulo 2^16.
- R9: While `busy` is high, new requests and `wr_en` are ignored.
- R10: If a bank swap and a stack exchange are requested in the same cycle, only the bank swap runs.
- R11: `done` is high for exactly one cycle, in the cycle after the last state, with `busy` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_swap_req | input | 1 | Start a bank swap |
| stk_xchg_req | input | 1 | Start a stack exchange |
| stk_use_index | input | 1 | Stack exchange target: 0 HL, 1 index register |
| stk_index_sel | input | 1 | Index register choice: 0 IX, 1 IY |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 4 | Register write select |
| wr_data | input | 16 | Register write data |
| rd_sel | input | 4 | Register read select |
| rd_data | output | 16 | Register read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
A bank swap request and a stack exchange request can fall in the same cycle. A bank swap request or a register write can also arrive in the middle of a running stack exchange. The bench raises both requests on one edge and checks three things: `busy` lasts only 4 states, no memory strobe appears, and the stack bytes are untouched. It also pulses a bank swap request and a write to the target register partway through a stack exchange. It then checks that the bus schedule, the written bytes and every register match a model in which neither intrusion happened.

// File: rtl/regx_pkg.sv
package regx_pkg;

    typedef enum logic [1:0] {
        OP_BANK   = 2'd0,
        OP_STK_HL = 2'd1,
        OP_STK_IX = 2'd2,
        OP_STK_IY = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ACT_IDLE  = 3'd0,
        ACT_RD_LO = 3'd1,
        ACT_RD_HI = 3'd2,
        ACT_WR_HI = 3'd3,
        ACT_WR_LO = 3'd4
    } act_e;

    // clock states per machine cycle kind
    localparam logic [2:0] LEN_IDLE  = 3'd4;
    localparam logic [2:0] LEN_RD_LO = 3'd3;
    localparam logic [2:0] LEN_RD_HI = 3'd4;
    localparam logic [2:0] LEN_WR_HI = 3'd3;
    localparam logic [2:0] LEN_WR_LO = 3'd5;

    // register select codes
    localparam logic [3:0] SEL_BC  = 4'd0;
    localparam logic [3:0] SEL_DE  = 4'd1;
    localparam logic [3:0] SEL_HL  = 4'd2;
    localparam logic [3:0] SEL_BCA = 4'd3;
    localparam logic [3:0] SEL_DEA = 4'd4;
    localparam logic [3:0] SEL_HLA = 4'd5;
    localparam logic [3:0] SEL_IX  = 4'd6;
    localparam logic [3:0] SEL_IY  = 4'd7;
    localparam logic [3:0] SEL_SP  = 4'd8;

    function automatic act_e step_act(input op_e op, input logic [2:0] mc);
        logic [2:0] adj;
        if (op == OP_BANK) return ACT_IDLE;
        if (op == OP_STK_HL) adj = mc;
        else if (mc == 3'd0) return ACT_IDLE;   // prefix cycle
        else adj = mc - 3'd1;
        case (adj)
            3'd1:    return ACT_RD_LO;
            3'd2:    return ACT_RD_HI;
            3'd3:    return ACT_WR_HI;
            3'd4:    return ACT_WR_LO;
            default: return ACT_IDLE;
        endcase
    endfunction

    function automatic logic [2:0] act_len(input act_e a);
        case (a)
            ACT_RD_LO: return LEN_RD_LO;
            ACT_RD_HI: return LEN_RD_HI;
            ACT_WR_HI: return LEN_WR_HI;
            ACT_WR_LO: return LEN_WR_LO;
            default:   return LEN_IDLE;
        endcase
    endfunction

    function automatic logic [2:0] last_mc(input op_e op);
        case (op)
            OP_BANK:   return 3'd0;
            OP_STK_HL: return 3'd4;
            default:   return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/regx_seq.sv
module regx_seq
    import regx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bank_req,
    input  logic stk_req,
    input  logic use_idx,
    input  logic idx_sel,
    output logic busy,
    output logic done,
    output op_e  op,
    output act_e act,
    output logic step_end,
    output logic op_end
);

    typedef struct packed {
        logic       busy;
        logic       done;
        op_e        op;
        logic [2:0] mc;
        logic [2:0] tc;
    } seq_t;

    seq_t s_d, s_q;
    logic [2:0] len;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        act      = s_q.busy ? step_act(s_q.op, s_q.mc) : ACT_IDLE;
        len      = act_len(act);
        step_end = s_q.busy && (s_q.tc == len - 3'd1);
        op_end   = step_end && (s_q.mc == last_mc(s_q.op));

        if (!s_q.busy) begin
            if (bank_req || stk_req) begin
                s_d.busy = 1'b1;
                s_d.mc   = 3'd0;
                s_d.tc   = 3'd0;
                if (bank_req)     s_d.op = OP_BANK;
                else if (!use_idx) s_d.op = OP_STK_HL;
                else if (idx_sel) s_d.op = OP_STK_IY;
                else              s_d.op = OP_STK_IX;
            end
        end else if (step_end) begin
            s_d.tc = 3'd0;
            if (op_end) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.mc = s_q.mc + 3'd1;
            end
        end else begin
            s_d.tc = s_q.tc + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{busy: 1'b0, done: 1'b0, op: OP_BANK, mc: 3'd0, tc: 3'd0};
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign op   = s_q.op;

endmodule

// File: rtl/regx_regs.sv
module regx_regs
    import regx_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [3:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              busy,
    input  op_e               op,
    input  act_e              act,
    input  logic              step_end,
    input  logic              op_end,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] sp
);

    typedef struct packed {
        logic [WORD_W-1:0] bc, de, hl;
        logic [WORD_W-1:0] bca, dea, hla;
        logic [WORD_W-1:0] ix, iy, sp;
        logic [BYTE_W-1:0] tlo, thi;
    } bank_t;

    bank_t r_d, r_q;
    logic [WORD_W-1:0] tgt;

    always_comb begin
        r_d = r_q;
        case (op)
            OP_STK_IX: tgt = r_q.ix;
            OP_STK_IY: tgt = r_q.iy;
            default:   tgt = r_q.hl;
        endcase
        mem_wdata = (act == ACT_WR_HI) ? tgt[WORD_W-1:BYTE_W] : tgt[BYTE_W-1:0];

        if (!busy && wr_en) begin
            case (wr_sel)
                SEL_BC:  r_d.bc  = wr_data;
                SEL_DE:  r_d.de  = wr_data;
                SEL_HL:  r_d.hl  = wr_data;
                SEL_BCA: r_d.bca = wr_data;
                SEL_DEA: r_d.dea = wr_data;
                SEL_HLA: r_d.hla = wr_data;
                SEL_IX:  r_d.ix  = wr_data;
                SEL_IY:  r_d.iy  = wr_data;
                SEL_SP:  r_d.sp  = wr_data;
                default: ;
            endcase
        end

        if (step_end && act == ACT_RD_LO) r_d.tlo = mem_rdata;
        if (step_end && act == ACT_RD_HI) r_d.thi = mem_rdata;

        if (op_end) begin
            case (op)
                OP_BANK: begin
                    r_d.bc  = r_q.bca; r_d.bca = r_q.bc;
                    r_d.de  = r_q.dea; r_d.dea = r_q.de;
                    r_d.hl  = r_q.hla; r_d.hla = r_q.hl;
                end
                OP_STK_HL: r_d.hl = {r_q.thi, r_q.tlo};
                OP_STK_IX: r_d.ix = {r_q.thi, r_q.tlo};
                default:   r_d.iy = {r_q.thi, r_q.tlo};
            endcase
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_BC:  rd_data = r_q.bc;
            SEL_DE:  rd_data = r_q.de;
            SEL_HL:  rd_data = r_q.hl;
            SEL_BCA: rd_data = r_q.bca;
            SEL_DEA: rd_data = r_q.dea;
            SEL_HLA: rd_data = r_q.hla;
            SEL_IX:  rd_data = r_q.ix;
            SEL_IY:  rd_data = r_q.iy;
            SEL_SP:  rd_data = r_q.sp;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sp = r_q.sp;

endmodule

// File: rtl/regx_unit.sv
module regx_unit
    import regx_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_swap_req,
    input  logic              stk_xchg_req,
    input  logic              stk_use_index,
    input  logic              stk_index_sel,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [3:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);

    op_e               op_w;
    act_e              act_w;
    logic              step_end_w;
    logic              op_end_w;
    logic [WORD_W-1:0] sp_w;

    regx_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_req (bank_swap_req),
        .stk_req  (stk_xchg_req),
        .use_idx  (stk_use_index),
        .idx_sel  (stk_index_sel),
        .busy     (busy),
        .done     (done),
        .op       (op_w),
        .act      (act_w),
        .step_end (step_end_w),
        .op_end   (op_end_w)
    );

    regx_regs #(.BYTE_W(BYTE_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .busy      (busy),
        .op        (op_w),
        .act       (act_w),
        .step_end  (step_end_w),
        .op_end    (op_end_w),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .sp        (sp_w)
    );

    always_comb begin
        mem_rd   = (act_w == ACT_RD_LO) || (act_w == ACT_RD_HI);
        mem_wr   = (act_w == ACT_WR_LO) || (act_w == ACT_WR_HI);
        mem_addr = ((act_w == ACT_RD_HI) || (act_w == ACT_WR_HI)) ? sp_w + 1'b1 : sp_w;
    end

endmodule

// File: rtl/regx_chk.sv
module regx_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bank_swap_req,
    input logic              stk_xchg_req,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] sp
);

    assert_done_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rd_wr_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_mem_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> busy);

    assert_addr_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr == sp || mem_addr == sp + 1'b1));

    assert_sp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sp));

    assert_start_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bank_swap_req || stk_xchg_req));

endmodule

bind regx_unit regx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_swap_req (bank_swap_req),
    .stk_xchg_req  (stk_xchg_req),
    .busy          (busy),
    .done          (done),
    .mem_rd        (mem_rd),
    .mem_wr        (mem_wr),
    .mem_addr      (mem_addr),
    .sp            (sp_w)
);

// File: tb/regx_unit_tb_top.sv
`timescale 1ns/1ps
module regx_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bank_swap_req = 1'b0, stk_xchg_req = 1'b0;
    logic        stk_use_index = 1'b0, stk_index_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0, rd_sel = '0;
    logic [15:0] wr_data = '0, rd_data, mem_addr;
    logic        busy, done, mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0;
    logic [15:0] mreg [9];
    logic [7:0]  mem [256];
    logic [23:0] exp_q [$];
    logic        pw = 1'b0;
    logic [15:0] pa = '0;

    always #2 clk = ~clk;

    regx_unit dut_i (.*);

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, got, exp);
        end
    endtask

    // scoreboard monitor: each new write transaction pops one expected item
    always @(negedge clk) begin
        if (rst_n && mem_wr && (!pw || mem_addr != pa)) begin
            if (exp_q.size() == 0) check("R10 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
            else check("R5 write data", {8'h0, mem_addr, mem_wdata}, {8'h0, exp_q.pop_front()});
        end
        pw = mem_wr;
        pa = mem_addr;
    end

    task automatic reg_write(input logic [3:0] sel, input logic [15:0] val);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk); wr_en = 1'b0;
        mreg[sel] = val;
    endtask

    task automatic verify_regs(input string rq);
        for (int i = 0; i < 9; i++) begin
            rd_sel = 4'(i);
            #0.2;
            check(rq, {16'h0, rd_data}, {16'h0, mreg[i]});
        end
    endtask

    task automatic do_bank(input string rq, input logic both);
        logic [15:0] t;
        @(negedge clk); bank_swap_req = 1'b1; stk_xchg_req = both;
        @(negedge clk); bank_swap_req = 1'b0; stk_xchg_req = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            check({rq, " busy/bus"}, {29'h0, busy, mem_rd, mem_wr}, 32'h4);
            @(negedge clk);
        end
        check({rq, " R11 done"}, {30'h0, done, busy}, 32'h2);
        for (int i = 0; i < 3; i++) begin
            t = mreg[i]; mreg[i] = mreg[i+3]; mreg[i+3] = t;
        end
        @(negedge clk);
        check({rq, " R11 done drop"}, {31'h0, done}, 32'h0);
        verify_regs(rq);
    endtask

    task automatic do_stack(input string rq, input logic ui, input logic is, input logic disturb);
        int          tsel = ui ? (is ? 7 : 6) : 2;
        int          n    = ui ? 23 : 19;
        int          pre  = ui ? 4 : 0;
        logic [15:0] sp   = mreg[8];
        logic [15:0] sp1  = mreg[8] + 16'd1;
        logic [15:0] old  = mreg[tsel];
        logic [15:0] nv;
        nv = {mem[sp1[7:0]], mem[sp[7:0]]};
        exp_q.push_back({sp1, old[15:8]});
        exp_q.push_back({sp, old[7:0]});
        @(negedge clk); stk_xchg_req = 1'b1; stk_use_index = ui; stk_index_sel = is;
        @(negedge clk); stk_xchg_req = 1'b0; stk_use_index = ~ui; stk_index_sel = ~is;
        for (int k = 1; k <= n; k++) begin
            int s = k - 1;
            logic [17:0] e;
            if (s < pre + 4)       e = {2'b00, 16'h0};
            else if (s < pre + 7)  e = {2'b10, sp};
            else if (s < pre + 11) e = {2'b10, sp1};
            else if (s < pre + 14) e = {2'b01, sp1};
            else                   e = {2'b01, sp};
            check({rq, " busy"}, {31'h0, busy}, 32'h1);
            check({rq, " bus schedule"}, {14'h0, mem_rd, mem_wr, (mem_rd | mem_wr) ? mem_addr : 16'h0},
                  {14'h0, e});
            if (disturb && k == 5) begin
                bank_swap_req = 1'b1; wr_en = 1'b1; wr_sel = 4'(tsel); wr_data = 16'hDEAD;
            end
            if (disturb && k == 6) begin
                bank_swap_req = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
        end
        check({rq, " R11 done"}, {30'h0, done, busy}, 32'h2);
        mreg[tsel] = nv;
        check({rq, " R5 mem hi"}, {24'h0, mem[sp1[7:0]]}, {24'h0, old[15:8]});
        check({rq, " R5 mem lo"}, {24'h0, mem[sp[7:0]]}, {24'h0, old[7:0]});
        @(negedge clk);
        check({rq, " R11 done drop"}, {31'h0, done}, 32'h0);
        verify_regs(rq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
        for (int i = 0; i < 9; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs", {28'h0, busy, done, mem_rd, mem_wr}, 32'h0);
        verify_regs("R1 regs");

        // R2 load every register
        for (int i = 0; i < 9; i++) reg_write(4'(i), 16'h1000 * 16'(i + 1) + 16'h0101 * 16'(i));
        reg_write(4'd8, 16'h0040);
        verify_regs("R2 write/read");

        // R3 / R4 bank swap twice
        do_bank("R3 bank swap", 1'b0);
        do_bank("R4 second swap restores", 1'b0);

        // R5 HL exchange, R8 SP kept
        do_stack("R5 stack HL", 1'b0, 1'b0, 1'b0);
        // R6/R7 IX exchange with R9 intrusions
        do_stack("R6 R7 R9 stack IX", 1'b1, 1'b0, 1'b1);
        do_stack("R7 stack IY", 1'b1, 1'b1, 1'b0);

        // R8 wrap at top of address space
        reg_write(4'd8, 16'hFFFF);
        do_stack("R8 wrap HL", 1'b0, 1'b0, 1'b0);

        // R10 simultaneous requests: bank only
        begin
            logic [7:0] m0, m1;
            m0 = mem[8'hFF]; m1 = mem[8'h00];
            do_bank("R10 both requests", 1'b1);
            check("R10 mem untouched", {16'h0, mem[8'hFF], mem[8'h00]}, {16'h0, m0, m1});
        end

        repeat (3) @(negedge clk);
        check("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule